// File: doc/BRIEF.md
# Speculative Byte-Masked Store Buffer Pool

This block keeps the stores made by speculative threads on a four-processor chip away from the shared second-level cache until each thread is known to be correct. A pool of five independent buffers is provided, one more than the processor count. While an older buffer is still writing its lines out, a processor that has just been freed can start a new thread in a spare buffer. Each buffer holds a few cache lines of 32 bytes, tagged by line address. Each line carries a per-byte mask of the bytes its thread has actually written. A 64-bit store, with a byte enable, either merges into a line already held under the same tag or claims a free line slot.

A more speculative thread can look up a line in an older thread's buffer. It gets back only the bytes that thread wrote, with the unwritten bytes zeroed, so that it can forward them. When the thread owning a buffer becomes the head (non-speculative) thread and commits, the buffer writes one line per cycle to the cache write port. It presents only the written bytes under a byte mask, raises a one-cycle done pulse once it is empty, and is free again. A violation throws the whole buffer away with no cache write. A store that needs a new line when all slots are taken raises a per-buffer stall. That stall stays high until the buffer's thread is the head.

Top module: `spec_store_pool`

## Requirements
- R1: A store to a buffer that already holds its line tag merges into that line. Byte i of the store lands at line byte `st_word*8 + i` wherever `st_be[i]` is 1, and overwrites earlier data there. The line's mask becomes the union of all enables written so far.
- R2: A store whose tag is not held takes the lowest free line slot, with a mask equal to its own shifted enables. A store with an all-zero byte enable changes nothing.
- R3: One cycle after a lookup (`lk_valid`, `lk_buf`, `lk_tag`), `lk_hit`, `lk_mask` and `lk_data` show the matching line, with bytes whose mask bit is 0 read as zero. A miss or an idle lookup gives all zeros.
- R4: A commit request takes effect only when `commit_buf` equals `head_buf`. Otherwise it is ignored and the buffer keeps its lines.
- R5: After an accepted commit, the buffer writes one line per cycle on `l2_we`/`l2_tag`/`l2_mask`/`l2_data`, starting on the second clock edge after the request, in slot order (the order the lines were first allocated). The mask is the line's written-byte mask, which is never zero, and unwritten data bytes are zero.
- R6: `drain_done[k]` pulses for exactly one cycle, on the edge after the last line is written (on the second edge after the request for an empty buffer). From then on, `buf_empty[k]` is 1.
- R7: Only the buffer whose index equals `head_buf` writes to the cache. If `head_buf` moves away during a drain, writes pause, and they resume where they stopped when it returns.
- R8: A violation (`vio_valid`, `vio_buf`) empties that buffer on the next edge, cancels any drain, clears its stall and writes nothing to the cache.
- R9: In a non-head buffer, a store that needs a new line while every slot is in use is dropped and raises `stall[k]`. The stall stays high until an edge at which `head_buf == k` (or a violation), and is low after that edge.
- R10: Stores sent to a buffer that is draining are ignored.
- R11: Buffers are independent. The same tag may live in several buffers with different data, and each answers lookups and drains with its own contents only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_buf | input | 3 | Target buffer of the store |
| st_tag | input | 11 | Line tag of the store |
| st_word | input | 2 | 8-byte word position inside the line |
| st_data | input | 64 | Store data, byte 0 in bits 7:0 |
| st_be | input | 8 | Store byte enables |
| lk_valid | input | 1 | Lookup request |
| lk_buf | input | 3 | Buffer to search |
| lk_tag | input | 11 | Line tag to search for |
| lk_hit | output | 1 | Lookup found the line (registered) |
| lk_data | output | 256 | Written bytes of the line, others zero |
| lk_mask | output | 32 | Written-byte mask of the line |
| head_buf | input | 3 | Buffer of the current non-speculative thread |
| commit_valid | input | 1 | Commit request |
| commit_buf | input | 3 | Buffer asked to commit |
| vio_valid | input | 1 | Violation on a thread |
| vio_buf | input | 3 | Buffer to discard |
| l2_we | output | 1 | Cache write strobe |
| l2_tag | output | 11 | Line tag being written |
| l2_data | output | 256 | Line data, unwritten bytes zero |
| l2_mask | output | 32 | Byte write mask for the cache |
| drain_done | output | 5 | Per-buffer one-cycle drain-complete pulse |
| stall | output | 5 | Per-buffer overflow stall |
| buf_empty | output | 5 | Per-buffer holds nothing and is not draining |

## Verification
On every cycle, the assertions check the stall rules (it holds while the thread is speculative and drops once it is head), that a violation leaves the buffer empty and unstalled, and that a done pulse is single-cycle and leaves the buffer empty. They also check that at most one buffer finishes per cycle, that cache writes always carry a non-zero mask, and that a missed lookup returns zeros. Only the bench's scenarios can show the contents: byte merging at the right offsets, overwrite order and zeroing of unwritten bytes. The same holds for drain order and data, for a commit from a non-head buffer being ignored, for draining pausing and resuming when the head moves, for stores during a drain being dropped, and for buffers with the same tag staying apart.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int SSB_NBUF   = 5;   // one buffer more than the processor count
  localparam int SSB_NENT   = 4;   // line slots per buffer
  localparam int SSB_TAG_W  = 11;  // line address bits
  localparam int SSB_LINE_B = 32;  // bytes per line
  localparam int SSB_WORD_B = 8;   // bytes per store
endpackage

// File: rtl/ssb_prio_pick.sv
module ssb_prio_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/ssb_buffer.sv
module ssb_buffer #(
  parameter int NENT   = 4,
  parameter int TAG_W  = 11,
  parameter int LINE_B = 32,
  parameter int WORD_B = 8,
  localparam int LINE_W = LINE_B * 8,
  localparam int WORD_W = WORD_B * 8,
  localparam int NWORD  = LINE_B / WORD_B,
  localparam int WSEL_W = (NWORD > 1) ? $clog2(NWORD) : 1,
  localparam int EI_W   = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_en,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [WSEL_W-1:0] st_word,
  input  logic [WORD_W-1:0] st_data,
  input  logic [WORD_B-1:0] st_be,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit_c,
  output logic [LINE_W-1:0] lk_data_c,
  output logic [LINE_B-1:0] lk_mask_c,
  input  logic              is_head,
  input  logic              commit_en,
  input  logic              vio_en,
  output logic              dr_we,
  output logic [TAG_W-1:0]  dr_tag,
  output logic [LINE_W-1:0] dr_data,
  output logic [LINE_B-1:0] dr_mask,
  output logic              done_o,
  output logic              stall_o,
  output logic              empty_o
);
  logic [NENT-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q [NENT];
  logic [LINE_W-1:0] dat_q [NENT];
  logic [LINE_B-1:0] msk_q [NENT];
  logic              drn_q;

  logic [NENT-1:0]   hit_v, lk_v;
  logic              ht_any, fr_any, dn_any, lk_any;
  logic [EI_W-1:0]   ht_idx, fr_idx, dn_idx, lk_idx, wr_idx;
  logic              st_act, wr_go, ovf, drain_go;
  logic [LINE_B-1:0] wr_be;
  logic [LINE_W-1:0] st_rep;

  function automatic logic [LINE_W-1:0] keep_bytes(input logic [LINE_W-1:0] d,
                                                   input logic [LINE_B-1:0] m);
    logic [LINE_W-1:0] r;
    for (int b = 0; b < LINE_B; b++) r[b*8 +: 8] = m[b] ? d[b*8 +: 8] : 8'h00;
    return r;
  endfunction

  always_comb begin
    for (int e = 0; e < NENT; e++) begin
      hit_v[e] = vld_q[e] && (tag_q[e] == st_tag);
      lk_v[e]  = vld_q[e] && (tag_q[e] == lk_tag);
    end
  end

  ssb_prio_pick #(.N(NENT)) u_hit  (.req(hit_v),  .any(ht_any), .idx(ht_idx));
  ssb_prio_pick #(.N(NENT)) u_free (.req(~vld_q), .any(fr_any), .idx(fr_idx));
  ssb_prio_pick #(.N(NENT)) u_drn  (.req(vld_q),  .any(dn_any), .idx(dn_idx));
  ssb_prio_pick #(.N(NENT)) u_look (.req(lk_v),   .any(lk_any), .idx(lk_idx));

  always_comb begin
    st_act   = st_en && (|st_be) && !drn_q;
    wr_go    = st_act && (ht_any || fr_any);
    ovf      = st_act && !ht_any && !fr_any;
    wr_idx   = ht_any ? ht_idx : fr_idx;
    wr_be    = LINE_B'(st_be) << (int'(st_word) * WORD_B);
    st_rep   = {NWORD{st_data}};
    drain_go = drn_q && is_head;
  end

  // line storage: no reset, byte-enabled writes
  always_ff @(posedge clk) begin
    if (wr_go) begin
      for (int b = 0; b < LINE_B; b++) begin
        if (wr_be[b]) dat_q[wr_idx][b*8 +: 8] <= st_rep[b*8 +: 8];
      end
      tag_q[wr_idx] <= st_tag;
      msk_q[wr_idx] <= ht_any ? (msk_q[wr_idx] | wr_be) : wr_be;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= '0;
      drn_q   <= 1'b0;
      stall_o <= 1'b0;
      done_o  <= 1'b0;
      dr_we   <= 1'b0;
      dr_tag  <= '0;
      dr_data <= '0;
      dr_mask <= '0;
    end else begin
      done_o <= 1'b0;
      dr_we  <= 1'b0;
      if (wr_go) vld_q[wr_idx] <= 1'b1;
      if (commit_en && is_head && !drn_q) drn_q <= 1'b1;
      if (drain_go) begin
        if (dn_any) begin
          dr_we         <= 1'b1;
          dr_tag        <= tag_q[dn_idx];
          dr_data       <= keep_bytes(dat_q[dn_idx], msk_q[dn_idx]);
          dr_mask       <= msk_q[dn_idx];
          vld_q[dn_idx] <= 1'b0;
        end else begin
          done_o <= 1'b1;
          drn_q  <= 1'b0;
        end
      end
      if (is_head)  stall_o <= 1'b0;
      else if (ovf) stall_o <= 1'b1;
      if (vio_en) begin
        vld_q   <= '0;
        drn_q   <= 1'b0;
        stall_o <= 1'b0;
      end
    end
  end

  assign lk_hit_c  = lk_any;
  assign lk_mask_c = lk_any ? msk_q[lk_idx] : '0;
  assign lk_data_c = lk_any ? keep_bytes(dat_q[lk_idx], msk_q[lk_idx]) : '0;
  assign empty_o   = ~(|vld_q) && !drn_q;
endmodule

// File: rtl/spec_store_pool.sv
module spec_store_pool #(
  parameter int NBUF   = ssb_pkg::SSB_NBUF,
  parameter int NENT   = ssb_pkg::SSB_NENT,
  parameter int TAG_W  = ssb_pkg::SSB_TAG_W,
  parameter int LINE_B = ssb_pkg::SSB_LINE_B,
  parameter int WORD_B = ssb_pkg::SSB_WORD_B,
  localparam int BUF_W  = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int LINE_W = LINE_B * 8,
  localparam int WORD_W = WORD_B * 8,
  localparam int WSEL_W = (LINE_B / WORD_B > 1) ? $clog2(LINE_B / WORD_B) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic [BUF_W-1:0]  st_buf,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [WSEL_W-1:0] st_word,
  input  logic [WORD_W-1:0] st_data,
  input  logic [WORD_B-1:0] st_be,
  input  logic              lk_valid,
  input  logic [BUF_W-1:0]  lk_buf,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [LINE_W-1:0] lk_data,
  output logic [LINE_B-1:0] lk_mask,
  input  logic [BUF_W-1:0]  head_buf,
  input  logic              commit_valid,
  input  logic [BUF_W-1:0]  commit_buf,
  input  logic              vio_valid,
  input  logic [BUF_W-1:0]  vio_buf,
  output logic              l2_we,
  output logic [TAG_W-1:0]  l2_tag,
  output logic [LINE_W-1:0] l2_data,
  output logic [LINE_B-1:0] l2_mask,
  output logic [NBUF-1:0]   drain_done,
  output logic [NBUF-1:0]   stall,
  output logic [NBUF-1:0]   buf_empty
);
  logic              b_hit  [NBUF];
  logic [LINE_W-1:0] b_ldat [NBUF];
  logic [LINE_B-1:0] b_lmsk [NBUF];
  logic              b_we   [NBUF];
  logic [TAG_W-1:0]  b_tag  [NBUF];
  logic [LINE_W-1:0] b_dat  [NBUF];
  logic [LINE_B-1:0] b_msk  [NBUF];

  for (genvar k = 0; k < NBUF; k++) begin : g_buf
    ssb_buffer #(
      .NENT(NENT), .TAG_W(TAG_W), .LINE_B(LINE_B), .WORD_B(WORD_B)
    ) u_buf (
      .clk       (clk),
      .rst       (rst),
      .st_en     (st_valid && (st_buf == BUF_W'(k))),
      .st_tag    (st_tag),
      .st_word   (st_word),
      .st_data   (st_data),
      .st_be     (st_be),
      .lk_tag    (lk_tag),
      .lk_hit_c  (b_hit[k]),
      .lk_data_c (b_ldat[k]),
      .lk_mask_c (b_lmsk[k]),
      .is_head   (head_buf == BUF_W'(k)),
      .commit_en (commit_valid && (commit_buf == BUF_W'(k))),
      .vio_en    (vio_valid && (vio_buf == BUF_W'(k))),
      .dr_we     (b_we[k]),
      .dr_tag    (b_tag[k]),
      .dr_data   (b_dat[k]),
      .dr_mask   (b_msk[k]),
      .done_o    (drain_done[k]),
      .stall_o   (stall[k]),
      .empty_o   (buf_empty[k])
    );
  end

  // lookup result registered one cycle after the request
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit  <= 1'b0;
      lk_data <= '0;
      lk_mask <= '0;
    end else begin
      lk_hit  <= 1'b0;
      lk_data <= '0;
      lk_mask <= '0;
      for (int k = 0; k < NBUF; k++) begin
        if (lk_valid && (lk_buf == BUF_W'(k))) begin
          lk_hit  <= b_hit[k];
          lk_data <= b_ldat[k];
          lk_mask <= b_lmsk[k];
        end
      end
    end
  end

  // drain ports are registered per buffer and only the head drains
  always_comb begin
    l2_we   = 1'b0;
    l2_tag  = '0;
    l2_data = '0;
    l2_mask = '0;
    for (int k = 0; k < NBUF; k++) begin
      if (b_we[k]) begin
        l2_we   = 1'b1;
        l2_tag  = l2_tag | b_tag[k];
        l2_data = l2_data | b_dat[k];
        l2_mask = l2_mask | b_msk[k];
      end
    end
  end
endmodule

// File: rtl/ssb_checker.sv
module ssb_checker #(
  parameter int NBUF   = 5,
  parameter int LINE_B = 32,
  parameter int LINE_W = 256,
  parameter int BUF_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [BUF_W-1:0]  head_buf,
  input logic              vio_valid,
  input logic [BUF_W-1:0]  vio_buf,
  input logic              lk_hit,
  input logic [LINE_W-1:0] lk_data,
  input logic [LINE_B-1:0] lk_mask,
  input logic              l2_we,
  input logic [LINE_B-1:0] l2_mask,
  input logic [NBUF-1:0]   drain_done,
  input logic [NBUF-1:0]   stall,
  input logic [NBUF-1:0]   buf_empty
);
  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_mask == '0 && lk_data == '0));

  // R5
  drain_mask_chk: assert property (@(posedge clk) disable iff (rst)
    l2_we |-> (l2_mask != '0));

  // R7
  one_finisher_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drain_done));

  for (genvar k = 0; k < NBUF; k++) begin : g_k
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (stall[k] && head_buf != BUF_W'(k) && !(vio_valid && vio_buf == BUF_W'(k)))
      |=> stall[k]);

    // R9
    stall_release_chk: assert property (@(posedge clk) disable iff (rst)
      (head_buf == BUF_W'(k)) |=> !stall[k]);

    // R8
    vio_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (vio_valid && vio_buf == BUF_W'(k)) |=> (buf_empty[k] && !stall[k]));

    // R6
    done_empty_chk: assert property (@(posedge clk) disable iff (rst)
      drain_done[k] |-> buf_empty[k]);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      drain_done[k] |=> !drain_done[k]);
  end
endmodule

bind spec_store_pool ssb_checker #(
  .NBUF(NBUF), .LINE_B(LINE_B), .LINE_W(LINE_W), .BUF_W(BUF_W)
) u_chk (
  .clk(clk), .rst(rst), .head_buf(head_buf), .vio_valid(vio_valid), .vio_buf(vio_buf),
  .lk_hit(lk_hit), .lk_data(lk_data), .lk_mask(lk_mask),
  .l2_we(l2_we), .l2_mask(l2_mask),
  .drain_done(drain_done), .stall(stall), .buf_empty(buf_empty)
);

// File: tb/test_spec_store_pool.sv
module test_spec_store_pool;
  localparam int NB = 5, NE = 4, TW = 11, BW = 3;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic st_valid = 0; logic [BW-1:0] st_buf = 0; logic [TW-1:0] st_tag = 0;
  logic [1:0] st_word = 0; logic [63:0] st_data = 0; logic [7:0] st_be = 0;
  logic lk_valid = 0; logic [BW-1:0] lk_buf = 0; logic [TW-1:0] lk_tag = 0;
  logic lk_hit; logic [255:0] lk_data; logic [31:0] lk_mask;
  logic [BW-1:0] head_buf = 0;
  logic commit_valid = 0; logic [BW-1:0] commit_buf = 0;
  logic vio_valid = 0; logic [BW-1:0] vio_buf = 0;
  logic l2_we; logic [TW-1:0] l2_tag; logic [255:0] l2_data; logic [31:0] l2_mask;
  logic [NB-1:0] drain_done, stall, buf_empty;

  spec_store_pool i_spec_store_pool (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model of each buffer
  logic [TW-1:0]  mtag [NB][NE];
  logic [255:0]   mdat [NB][NE];
  logic [31:0]    mmsk [NB][NE];
  int             mn   [NB];
  bit             mdrn [NB];

  logic [TW-1:0]  qtag [$];
  logic [255:0]   qdat [$];
  logic [31:0]    qmsk [$];

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // scoreboard monitor for cache writes (R5, R7, R8)
  always @(posedge clk) begin
    #1;
    if (!rst && l2_we) begin
      if (qtag.size() == 0) chk("R5 unexpected cache write", 256'(l2_tag), 256'h0);
      else begin
        logic [TW-1:0] t; logic [255:0] d; logic [31:0] m;
        t = qtag.pop_front(); d = qdat.pop_front(); m = qmsk.pop_front();
        chk("R5 drain tag", 256'(l2_tag), 256'(t));
        chk("R5 drain mask", 256'(l2_mask), 256'(m));
        chk("R5 drain data", l2_data, d);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic do_store(input int b, input logic [TW-1:0] t, input int w,
                          input logic [63:0] d, input logic [7:0] be);
    int e;
    @(negedge clk);
    st_valid = 1; st_buf = BW'(b); st_tag = t; st_word = 2'(w); st_data = d; st_be = be;
    if (be != 0 && !mdrn[b]) begin
      e = -1;
      for (int i = 0; i < mn[b]; i++) if (mtag[b][i] == t) e = i;
      if (e < 0 && mn[b] < NE) begin
        e = mn[b]; mn[b]++; mtag[b][e] = t; mdat[b][e] = '0; mmsk[b][e] = '0;
      end
      if (e >= 0)
        for (int i = 0; i < 8; i++) if (be[i]) begin
          mdat[b][e][(w*8+i)*8 +: 8] = d[i*8 +: 8];
          mmsk[b][e][w*8+i] = 1'b1;
        end
    end
    cyc();
    st_valid = 0;
  endtask

  task automatic do_lookup(input int b, input logic [TW-1:0] t, input string req);
    logic eh; logic [255:0] ed; logic [31:0] em;
    eh = 0; ed = '0; em = '0;
    for (int i = 0; i < mn[b]; i++)
      if (mtag[b][i] == t) begin eh = 1; ed = mdat[b][i]; em = mmsk[b][i]; end
    @(negedge clk);
    lk_valid = 1; lk_buf = BW'(b); lk_tag = t;
    cyc();
    lk_valid = 0;
    chk({req, " lookup hit"}, 256'(lk_hit), 256'(eh));
    chk({req, " lookup mask"}, 256'(lk_mask), 256'(em));
    chk({req, " lookup data"}, lk_data, ed);
  endtask

  task automatic do_commit(input int b);
    @(negedge clk);
    commit_valid = 1; commit_buf = BW'(b);
    if (int'(head_buf) == b && !mdrn[b]) begin
      for (int i = 0; i < mn[b]; i++) begin
        qtag.push_back(mtag[b][i]); qdat.push_back(mdat[b][i]); qmsk.push_back(mmsk[b][i]);
      end
      mn[b] = 0; mdrn[b] = 1;
    end
    cyc();
    commit_valid = 0;
  endtask

  task automatic wait_done(input int b);
    int n = 0;
    while (drain_done[b] !== 1'b1 && n < 40) begin cyc(); n++; end
    chk("R6 done pulse seen", 256'(drain_done[b]), 256'h1);
    chk("R5 all lines drained", 256'(qtag.size()), 256'h0);
    cyc();
    chk("R6 done one cycle", 256'(drain_done[b]), 256'h0);
    chk("R6 empty after drain", 256'(buf_empty[b]), 256'h1);
    mdrn[b] = 0;
  endtask

  task automatic set_head(input int b);
    @(negedge clk); head_buf = BW'(b);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin mn[b] = 0; mdrn[b] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    cyc();
    // reset state
    chk("R6 reset empty", 256'(buf_empty), 256'h1f);
    chk("R9 reset stall", 256'(stall), 256'h0);
    chk("R5 reset no write", 256'(l2_we), 256'h0);
    chk("R3 reset no hit", 256'(lk_hit), 256'h0);

    // R1/R2 merge and allocate in buffer 0
    do_store(0, 11'h0a5, 0, 64'h1122334455667788, 8'hff);
    do_store(0, 11'h0a5, 2, 64'hdeadbeefcafef00d, 8'h0f);
    do_store(0, 11'h13c, 1, 64'h0102030405060708, 8'h3c);
    do_store(0, 11'h0a5, 0, 64'h00000000000000ee, 8'h01);
    do_lookup(0, 11'h0a5, "R1");
    do_lookup(0, 11'h13c, "R2");
    do_lookup(0, 11'h777, "R3 miss");
    do_lookup(1, 11'h0a5, "R11 other buffer");
    // R2 zero enable
    do_store(0, 11'h2d2, 3, 64'hffffffffffffffff, 8'h00);
    do_lookup(0, 11'h2d2, "R2 zero enable");

    // R4 commit from non-head ignored
    set_head(1);
    do_commit(0);
    repeat (4) cyc();
    chk("R4 non-head commit ignored", 256'(buf_empty[0]), 256'h0);
    do_lookup(0, 11'h0a5, "R4 lines kept");

    // R5/R6/R10 commit head buffer 0, store during drain
    set_head(0);
    do_commit(0);
    do_store(0, 11'h055, 0, 64'h5555, 8'h03);
    wait_done(0);
    do_lookup(0, 11'h055, "R10 store during drain");

    // R9 overflow on buffer 1 (not head)
    for (int i = 0; i < NE; i++) do_store(1, TW'(11'h100 + i), i % 4, 64'h1000 + 64'(i), 8'h81);
    chk("R9 no stall while room", 256'(stall[1]), 256'h0);
    do_store(1, 11'h1ff, 0, 64'hbad, 8'hff);
    chk("R9 stall on overflow", 256'(stall[1]), 256'h1);
    repeat (3) cyc();
    chk("R9 stall held", 256'(stall[1]), 256'h1);
    chk("R11 other stall low", 256'(stall[0]), 256'h0);
    do_lookup(1, 11'h1ff, "R9 dropped store");
    set_head(1);
    cyc();
    chk("R9 stall released at head", 256'(stall[1]), 256'h0);

    // R7 drain pause when head moves
    do_commit(1);
    cyc();
    chk("R7 first line written", 256'(l2_we), 256'h1);
    set_head(0);
    cyc();
    chk("R7 paused off head", 256'(l2_we), 256'h0);
    cyc();
    chk("R7 still paused", 256'(qtag.size()), 256'(NE - 1));
    set_head(1);
    wait_done(1);

    // R8 violation on buffer 2 with stall raised
    for (int i = 0; i < NE; i++) do_store(2, TW'(11'h200 + i), 1, 64'habcd0000 + 64'(i), 8'hf0);
    do_store(2, 11'h2ff, 0, 64'h1, 8'h01);
    chk("R9 stall buffer 2", 256'(stall[2]), 256'h1);
    @(negedge clk); vio_valid = 1; vio_buf = 3'd2;
    for (int b = 0; b < 1; b++) mn[2] = 0;
    cyc(); vio_valid = 0;
    chk("R8 empty after violation", 256'(buf_empty[2]), 256'h1);
    chk("R8 stall cleared", 256'(stall[2]), 256'h0);
    do_lookup(2, 11'h201, "R8 discarded");
    set_head(2);
    do_commit(2);
    wait_done(2);

    // R11 same tag in two buffers
    do_store(3, 11'h3a3, 1, 64'h3333333333333333, 8'hff);
    do_store(4, 11'h3a3, 1, 64'h4444444444444444, 8'h18);
    do_lookup(3, 11'h3a3, "R11 buffer 3");
    do_lookup(4, 11'h3a3, "R11 buffer 4");
    set_head(3);
    do_commit(3);
    wait_done(3);
    do_lookup(4, 11'h3a3, "R11 kept after neighbour drain");

    repeat (3) cyc();
    chk("R5 no stray writes", 256'(qtag.size()), 256'h0);
    summary();
  end
endmodule